// File: doc/BRIEF.md
# Prioritised Multi-Context Interrupt Router

This block collects level-sensitive interrupt requests from a set of numbered sources and delivers them to several processor contexts. Software gives each source a priority. Each context gets its own set of source enables and its own priority threshold. A context's interrupt line is raised while at least one source enabled for it is pending with a priority strictly above that context's threshold.

A handler takes an interrupt by reading its context's claim/complete register. The read returns the identifier of the best eligible source, or zero when there is none. The read also takes that source out of arbitration. When the handler is done, it writes the same identifier back to the same register. Until that write, the source cannot pend again or be delivered to any context. Source identifier 0 is reserved and never used.

Register access goes through a single-cycle port. Read data is combinational from the address, and a write or the side effect of a claim takes effect on the rising clock edge that samples the request. The default build has 31 sources, 2 contexts and 3-bit priorities.

Top module: `irq_router`

## Requirements
- R1: After reset every priority, enable and threshold reads zero, all `irq_o` bits are low, and a claim read returns 0.
- R2: The priority of source n is at byte address 4*n. Only the low 3 bits are stored, and the upper bits read as zero. Address 0 (source 0) always reads zero, and writes to it are ignored.
- R3: The enables of context c are at byte address 0x2000 + 0x80*c. Source n is bit n%32 of word n/32. Bit 0 of word 0 (source 0) always reads zero.
- R4: The threshold of context c is at byte address 0x200000 + 0x1000*c. Only the low 3 bits are stored.
- R5: `irq_o[c]` is high exactly when some source is pending, is enabled for context c, and has a priority strictly greater than the threshold of context c. A priority of 0 never delivers, and a threshold of 7 masks every source.
- R6: A read of the claim/complete register at 0x200004 + 0x1000*c returns the highest-priority eligible source for context c. On a tie the lowest identifier wins. The read returns 0 when no source is eligible.
- R7: A claim clears the source's pending state and marks it claimed. While claimed, the source is not pended or delivered again, even with its input held high. If no other source is eligible, `irq_o[c]` is low in the cycle after the claim.
- R8: Writing a claimed identifier to the claim/complete register of a context that has that source enabled releases the claim. If the input is still high, the source pends again on the next clock edge.
- R9: A completion write is ignored when its identifier is not currently claimed, or when the source is not enabled for the context written.
- R10: A high input level that lasts a single cycle latches the source as pending. The source stays pending after the input falls, until it is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_level_i | input | NUM_SRC (bits NUM_SRC..1) | Level request of each source; bit n is source n |
| bus_valid_i | input | 1 | Register access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | NUM_CTX | Interrupt line of each context |

## Verification
The assertions watch the per-source gateway on every cycle. A claim must move a source from pending to claimed. A pending source stays pending until it is claimed, and a claimed source stays claimed until a completion releases it. A claimed source is never pending. Another assertion checks that a raised context line always has a winning priority above that context's threshold. The bench scenarios cover what only stimulus sequences can show: address decode and field masking, tie-break order across several claims, the strict threshold comparison, the rejection of a stray or foreign completion, and the latching of a one-cycle pulse.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
  localparam logic [11:0] THR_OFS    = 12'h000;
  localparam logic [11:0] CLAIM_OFS  = 12'h004;

  // True when addr falls inside count consecutive blocks of size stride from base.
  function automatic logic in_window(input logic [31:0] addr, input logic [31:0] base,
                                     input logic [31:0] stride, input logic [31:0] count);
    return (addr >= base) && (addr < base + stride * count);
  endfunction

  // A source may reach a context only when pending, enabled and strictly above threshold.
  function automatic logic eligible(input logic pend, input logic en,
                                    input logic [31:0] prio, input logic [31:0] thr);
    return pend && en && (prio > thr);
  endfunction

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic take_i,
  input  logic done_i,
  output logic pending_o,
  output logic claimed_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_o <= 1'b0;
      claimed_o <= 1'b0;
    end else begin
      if (take_i) begin
        pending_o <= 1'b0;
        claimed_o <= 1'b1;
      end else begin
        if (done_i) claimed_o <= 1'b0;
        if (level_i && !pending_o && !claimed_o) pending_o <= 1'b1;
      end
    end
  end

  // R7: a claim moves the source out of pending into claimed
  a_r7_take_moves: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (claimed_o && !pending_o));

  // R7: a claimed source is never pending again
  a_r7_no_repend: assert property (@(posedge clk) disable iff (!rst_n)
    claimed_o |-> !pending_o);

  // R10: pending holds until claimed
  a_r10_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !take_i) |=> pending_o);

  // R9: the claim survives every cycle without a completion
  a_r9_claim_held: assert property (@(posedge clk) disable iff (!rst_n)
    (claimed_o && !done_i) |=> claimed_o);

  // R8: a completion releases the claim
  a_r8_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !claimed_o);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  localparam int IDW    = $clog2(NUM_SRC + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC:0]                pend_i,
  input  logic [NUM_SRC:0]                en_i,
  input  logic [NUM_SRC:0][PRIO_W-1:0]    prio_i,
  input  logic [PRIO_W-1:0]               thr_i,
  output logic [IDW-1:0]                  best_id_o,
  output logic                            irq_o
);
  import irq_router_pkg::*;

  logic [PRIO_W-1:0] best_prio;
  logic              found;

  // Scan in ascending identifier order; only a strictly higher priority
  // replaces the current winner, so ties keep the lowest identifier.
  always_comb begin
    best_id_o = '0;
    best_prio = '0;
    found     = 1'b0;
    for (int i = 0; i <= NUM_SRC; i++) begin
      if (eligible(pend_i[i], en_i[i], 32'(prio_i[i]), 32'(thr_i)) &&
          (!found || prio_i[i] > best_prio)) begin
        found     = 1'b1;
        best_prio = prio_i[i];
        best_id_o = IDW'(i);
      end
    end
  end

  assign irq_o = found;

  // R5: a raised line always carries a winner above the context threshold
  a_r5_irq_above_thr: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (best_prio > thr_i && best_id_o != '0));

endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC:1]   src_level_i,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic [NUM_CTX-1:0] irq_o
);
  import irq_router_pkg::*;

  localparam int IDW      = $clog2(NUM_SRC + 1);
  localparam int CW       = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int EN_WORDS = (NUM_SRC + 32) / 32;
  localparam int WW       = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;

  // Register state
  logic [NUM_SRC:0][PRIO_W-1:0]              prio_q;
  logic [NUM_CTX-1:0][NUM_SRC:0]             en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0]            thr_q;

  // Gateway and arbiter interconnect
  logic [NUM_SRC:0]                          pend;
  logic [NUM_SRC:0]                          claimed;
  logic [NUM_SRC:0]                          take_vec;
  logic [NUM_SRC:0]                          done_vec;
  logic [NUM_CTX-1:0][IDW-1:0]               ctx_best;

  // Decode
  logic [31:0]     a, en_rel, ctx_rel;
  logic            rd, wr;
  logic            hit_prio, hit_en, hit_thr, hit_claim, in_ctx;
  logic [IDW-1:0]  dec_id;
  logic [CW-1:0]   en_ctx, ctl_ctx;
  logic [WW-1:0]   en_word;
  logic            wd_ok;
  logic [IDW-1:0]  wd_id;
  logic [IDW-1:0]  claim_ctx_id;

  always_comb begin
    a         = 32'(bus_addr_i);
    rd        = bus_valid_i && !bus_write_i;
    wr        = bus_valid_i && bus_write_i;
    hit_prio  = (a < 32'(4 * (NUM_SRC + 1))) && (a[1:0] == 2'b00);
    dec_id    = IDW'(a >> 2);
    en_rel    = a - EN_BASE;
    hit_en    = in_window(a, EN_BASE, EN_STRIDE, 32'(NUM_CTX)) && (a[1:0] == 2'b00) &&
                (32'(en_rel[6:2]) < 32'(EN_WORDS));
    en_ctx    = CW'(en_rel >> 7);
    en_word   = WW'(en_rel[6:2]);
    ctx_rel   = a - CTX_BASE;
    in_ctx    = in_window(a, CTX_BASE, CTX_STRIDE, 32'(NUM_CTX));
    hit_thr   = in_ctx && (ctx_rel[11:0] == THR_OFS);
    hit_claim = in_ctx && (ctx_rel[11:0] == CLAIM_OFS);
    ctl_ctx   = CW'(ctx_rel >> 12);
    wd_ok     = (bus_wdata_i != 32'd0) && (bus_wdata_i <= 32'(NUM_SRC));
    wd_id     = IDW'(bus_wdata_i);
    claim_ctx_id = ctx_best[ctl_ctx];
  end

  // Claim and completion events, one pair per source
  always_comb begin
    for (int i = 0; i <= NUM_SRC; i++) begin
      take_vec[i] = (i != 0) && rd && hit_claim && (claim_ctx_id == IDW'(i));
      done_vec[i] = (i != 0) && wr && hit_claim && wd_ok && (wd_id == IDW'(i)) &&
                    claimed[i] && en_q[ctl_ctx][i];
    end
  end

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr) begin
      if (hit_prio && dec_id != '0) prio_q[dec_id] <= bus_wdata_i[PRIO_W-1:0];
      if (hit_en) begin
        for (int i = 1; i <= NUM_SRC; i++) begin
          if (32'(en_word) == 32'(i / 32)) en_q[en_ctx][i] <= bus_wdata_i[i % 32];
        end
      end
      if (hit_thr) thr_q[ctl_ctx] <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  // Read mux
  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      if (hit_prio && dec_id != '0) begin
        bus_rdata_o = 32'(prio_q[dec_id]);
      end else if (hit_en) begin
        for (int i = 1; i <= NUM_SRC; i++) begin
          if (32'(en_word) == 32'(i / 32)) bus_rdata_o[i % 32] = en_q[en_ctx][i];
        end
      end else if (hit_thr) begin
        bus_rdata_o = 32'(thr_q[ctl_ctx]);
      end else if (hit_claim) begin
        bus_rdata_o = 32'(claim_ctx_id);
      end
    end
  end

  assign pend[0]    = 1'b0;
  assign claimed[0] = 1'b0;

  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_gw
    irq_gateway u_gw (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_i   (src_level_i[g]),
      .take_i    (take_vec[g]),
      .done_i    (done_vec[g]),
      .pending_o (pend[g]),
      .claimed_o (claimed[g])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irq_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_i    (pend),
      .en_i      (en_q[c]),
      .prio_i    (prio_q),
      .thr_i     (thr_q[c]),
      .best_id_o (ctx_best[c]),
      .irq_o     (irq_o[c])
    );
  end

endmodule

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;

  localparam int NS = 31;
  localparam int NC = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS:1]       src = '0;
  logic              bv = 1'b0, bw = 1'b0;
  logic [23:0]       ba = '0;
  logic [31:0]       bwd = '0;
  logic [31:0]       brd;
  logic [NC-1:0]     irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rst_n(rst_n), .src_level_i(src),
    .bus_valid_i(bv), .bus_write_i(bw), .bus_addr_i(ba), .bus_wdata_i(bwd),
    .bus_rdata_o(brd), .irq_o(irq)
  );

  function automatic logic [23:0] prio_a(int n); return 24'(4 * n); endfunction
  function automatic logic [23:0] en_a(int c);   return 24'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [23:0] thr_a(int c);  return 24'(32'h200000 + 32'h1000 * c); endfunction
  function automatic logic [23:0] clm_a(int c);  return 24'(32'h200004 + 32'h1000 * c); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [23:0] addr, logic [31:0] data);
    @(negedge clk);
    bv = 1'b1; bw = 1'b1; ba = addr; bwd = data;
    @(negedge clk);
    bv = 1'b0; bw = 1'b0;
    #1;
  endtask

  task automatic bus_read(logic [23:0] addr, output logic [31:0] data);
    @(negedge clk);
    bv = 1'b1; bw = 1'b0; ba = addr;
    #1 data = brd;
    @(negedge clk);
    bv = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    src = '0; bv = 1'b0; bw = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 irq after reset", 32'(irq), 0);
    bus_read(prio_a(1), d);  chk("R1 priority after reset", d, 0);
    bus_read(en_a(0), d);    chk("R1 enables after reset", d, 0);
    bus_read(thr_a(1), d);   chk("R1 threshold after reset", d, 0);
    bus_read(clm_a(0), d);   chk("R1 claim after reset", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    bus_write(prio_a(5), 32'hFFFF_FFFF);
    bus_read(prio_a(5), d);  chk("R2 priority masked to 3 bits", d, 7);
    bus_write(prio_a(31), 3);
    bus_read(prio_a(31), d); chk("R2 last source priority", d, 3);
    bus_write(prio_a(0), 7);
    bus_read(prio_a(0), d);  chk("R2 source 0 priority stays zero", d, 0);
    bus_write(en_a(1), 32'hFFFF_FFFF);
    bus_read(en_a(1), d);    chk("R3 context 1 enables, bit 0 zero", d, 32'hFFFF_FFFE);
    bus_read(en_a(0), d);    chk("R3 context 0 enables untouched", d, 0);
    bus_write(thr_a(1), 32'hFF);
    bus_read(thr_a(1), d);   chk("R4 threshold masked to 3 bits", d, 7);
    bus_read(thr_a(0), d);   chk("R4 other threshold untouched", d, 0);
  endtask

  task automatic t_delivery();
    do_reset();
    bus_write(prio_a(3), 2);
    bus_write(en_a(0), 32'h8);
    bus_write(thr_a(0), 1);
    src[3] = 1'b1;
    tick(2); #1;
    chk("R5 irq0 for priority above threshold", 32'(irq[0]), 1);
    chk("R5 irq1 without enable", 32'(irq[1]), 0);
    bus_write(thr_a(0), 2);
    chk("R5 equal priority and threshold masks", 32'(irq[0]), 0);
    bus_write(thr_a(0), 7);
    chk("R5 max threshold masks", 32'(irq[0]), 0);
    bus_write(thr_a(0), 0);
    chk("R5 threshold 0 passes", 32'(irq[0]), 1);
    bus_write(en_a(1), 32'h8);
    chk("R3 context 1 enable bit 3 delivers", 32'(irq[1]), 1);
    bus_write(prio_a(3), 0);
    chk("R5 priority 0 never delivers", 32'(irq), 0);
  endtask

  task automatic t_arbitration();
    logic [31:0] d;
    do_reset();
    bus_write(prio_a(4), 5);
    bus_write(prio_a(6), 5);
    bus_write(prio_a(2), 3);
    bus_write(en_a(0), 32'h54);
    src[2] = 1'b1; src[4] = 1'b1; src[6] = 1'b1;
    tick(2); #1;
    chk("R5 irq0 with three sources", 32'(irq), 1);
    bus_read(clm_a(0), d);  chk("R6 tie goes to lowest id", d, 4);
    bus_read(clm_a(0), d);  chk("R7 claimed 4 not redelivered", d, 6);
    bus_read(clm_a(0), d);  chk("R6 lower priority last", d, 2);
    chk("R7 irq0 low after last claim", 32'(irq[0]), 0);
    bus_read(clm_a(0), d);  chk("R6 empty claim reads 0", d, 0);
    bus_write(clm_a(1), 6);
    tick(2); #1;
    chk("R9 completion from non-enabled context ignored", 32'(irq[0]), 0);
    bus_write(clm_a(0), 9);
    tick(2); #1;
    chk("R9 completion of unclaimed id ignored", 32'(irq[0]), 0);
    bus_write(clm_a(0), 4);
    tick(1); #1;
    chk("R8 completion repends held source", 32'(irq[0]), 1);
    bus_read(clm_a(0), d);  chk("R8 released source claimable", d, 4);
    bus_write(clm_a(0), 6);
    tick(1); #1;
    bus_read(clm_a(0), d);  chk("R9 6 was still claimed until completed", d, 6);
  endtask

  task automatic t_pulse();
    logic [31:0] d;
    do_reset();
    bus_write(prio_a(10), 1);
    bus_write(en_a(0), 32'h400);
    @(negedge clk); src[10] = 1'b1;
    @(negedge clk); src[10] = 1'b0;
    tick(3); #1;
    chk("R10 one-cycle pulse latched", 32'(irq[0]), 1);
    bus_read(clm_a(0), d);  chk("R10 latched source claimed", d, 10);
    chk("R7 irq0 drops after claim", 32'(irq[0]), 0);
    bus_write(clm_a(0), 10);
    tick(2); #1;
    chk("R8 completion without level leaves idle", 32'(irq[0]), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_regs();
    t_delivery();
    t_arbitration();
    t_pulse();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule